// File: doc/BRIEF.md
# Turbo Component Decoder Branch Metric and Extrinsic Unit

This block sits beside the state-metric recursions of a rate-1/3 turbo component decoder, where each trellis stage carries one systematic and one parity bit. For every incoming symbol it forms the four branch metrics from the a-priori value and the two scaled channel values. It computes and stores only the two metrics whose systematic bit is +1, because the other two are their exact negations. The stored pair waits in a ring buffer until the recursions deliver the a-posteriori LLR for that symbol.

When the LLR arrives, the block subtracts the sum of the two stored metrics to form the extrinsic value. That sum equals the a-priori term plus the systematic channel term, so the a-priori input never needs a buffer of its own. The LLRs come back window by window, and within each window of `WIN` symbols they arrive in reverse order. The read side follows that order without an external address.

Top module: `llr_branch_extrinsic`

## Requirements
- R1: All values are two's complement. Let t1 = floor((apri + lc_ys)/2) and t2 = floor(lc_yp/2), where each division is an arithmetic right shift by one. One clock after a cycle with `in_valid` high, `gam3` shows sat10(t1 + t2).
- R2: Under the same timing, `gam2` shows sat10(t1 − t2).
- R3: Under the same timing, `gam1` shows sat10(−gam2) and `gam0` shows sat10(−gam3). Neither of them ever equals −512.
- R4: sat10 clamps to [−512, 511] and never wraps. This covers the forming of both sums and the two negations.
- R5: `gam_valid` is `in_valid` delayed by one clock. After a cycle with `in_valid` low, the four metrics keep their previous values.
- R6: One clock after a cycle with `llr_valid` high, `ext_valid` is high and `ext` shows sat9(llr − (g2 + g3)). Here g2 and g3 are the saturated metrics of the symbol that this LLR belongs to, and sat9 clamps to [−256, 255].
- R7: Symbols are numbered from 0 in write order. The k-th accepted LLR (k counted from 0) belongs to symbol WIN·floor(k/WIN) + WIN−1 − (k mod WIN). The buffer holds NWIN·WIN symbols, and windows are consumed in write order.
- R8: While `rst_n` is low, both valid outputs and all data outputs are zero, and both buffer pointers return to symbol 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | New symbol present on the three inputs |
| apri | input | AW (9) | A-priori value, signed |
| lc_ys | input | CW (10) | Scaled systematic channel value, signed |
| lc_yp | input | CW (10) | Scaled parity channel value, signed |
| gam_valid | output | 1 | Metrics updated this cycle |
| gam3 | output | BW (10) | Metric for codeword (+1,+1) |
| gam2 | output | BW (10) | Metric for codeword (+1,−1) |
| gam1 | output | BW (10) | Metric for codeword (−1,+1) |
| gam0 | output | BW (10) | Metric for codeword (−1,−1) |
| llr_valid | input | 1 | A-posteriori LLR present |
| llr | input | LW (12) | A-posteriori LLR, signed |
| ext_valid | output | 1 | Extrinsic output valid |
| ext | output | AW (9) | Extrinsic value, signed |

## Verification
A wrong metric or a wrong saturation shows on the four metric outputs one clock after the symbol enters, so the per-clock comparison catches it at once. A fault in the stored pair or in the read addressing stays hidden until the LLR of the affected symbol returns, which can be up to several windows later. It then appears as a wrong `ext` one clock after that LLR. A read order that is mirrored, or a window base that advances wrongly, breaks nearly every extrinsic value of the window. The bench therefore runs more windows than the ring holds, so that the wrap of the write and read pointers is exercised.

// File: rtl/llr_branch_extrinsic.sv
module llr_branch_extrinsic #(
  parameter int AW   = 9,
  parameter int CW   = 10,
  parameter int BW   = 10,
  parameter int LW   = 12,
  parameter int WIN  = 40,
  parameter int NWIN = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [AW-1:0] apri,
  input  logic signed [CW-1:0] lc_ys,
  input  logic signed [CW-1:0] lc_yp,
  output logic                 gam_valid,
  output logic signed [BW-1:0] gam3,
  output logic signed [BW-1:0] gam2,
  output logic signed [BW-1:0] gam1,
  output logic signed [BW-1:0] gam0,
  input  logic                 llr_valid,
  input  logic signed [LW-1:0] llr,
  output logic                 ext_valid,
  output logic signed [AW-1:0] ext
);

  localparam int XW    = ((AW > CW) ? AW : CW) + 1;
  localparam int SW    = XW + 1;
  localparam int DW    = ((LW > BW + 1) ? LW : BW + 1) + 1;
  localparam int DEPTH = WIN * NWIN;
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OW    = (WIN > 1) ? $clog2(WIN) : 1;

  localparam logic signed [SW-1:0] BM_HI = SW'((2 ** (BW - 1)) - 1);
  localparam logic signed [SW-1:0] BM_LO = SW'(-(2 ** (BW - 1)));
  localparam logic signed [DW-1:0] EX_HI = DW'((2 ** (AW - 1)) - 1);
  localparam logic signed [DW-1:0] EX_LO = DW'(-(2 ** (AW - 1)));
  localparam logic signed [BW-1:0] GMIN  = {1'b1, {(BW-1){1'b0}}};

  function automatic logic signed [BW-1:0] sat_bm(input logic signed [SW-1:0] v);
    if (v > BM_HI) return BM_HI[BW-1:0];
    if (v < BM_LO) return BM_LO[BW-1:0];
    return v[BW-1:0];
  endfunction

  function automatic logic signed [AW-1:0] sat_ex(input logic signed [DW-1:0] v);
    if (v > EX_HI) return EX_HI[AW-1:0];
    if (v < EX_LO) return EX_LO[AW-1:0];
    return v[AW-1:0];
  endfunction

  // metric formation
  logic signed [XW-1:0] sum_s, th1;
  logic signed [CW-1:0] th2;
  logic signed [BW-1:0] g3_s, g2_s, g1_s, g0_s;

  assign sum_s = $signed({{(XW-AW){apri[AW-1]}}, apri}) + $signed({{(XW-CW){lc_ys[CW-1]}}, lc_ys});
  assign th1   = sum_s >>> 1;
  assign th2   = lc_yp >>> 1;
  assign g3_s  = sat_bm(SW'(th1) + SW'(th2));
  assign g2_s  = sat_bm(SW'(th1) - SW'(th2));
  assign g0_s  = sat_bm(-SW'(g3_s));
  assign g1_s  = sat_bm(-SW'(g2_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gam_valid <= 1'b0;
      gam3 <= '0;
      gam2 <= '0;
      gam1 <= '0;
      gam0 <= '0;
    end else begin
      gam_valid <= in_valid;
      if (in_valid) begin
        gam3 <= g3_s;
        gam2 <= g2_s;
        gam1 <= g1_s;
        gam0 <= g0_s;
      end
    end
  end

  // half-metric ring buffer
  logic [2*BW-1:0] mem [DEPTH];
  logic [PW-1:0]   wp, rbase, raddr;
  logic [OW-1:0]   roff;

  always_ff @(posedge clk) begin
    if (in_valid) mem[wp] <= {g3_s, g2_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wp <= '0;
    else if (in_valid) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
  end

  assign raddr = rbase + PW'(WIN - 1) - PW'(roff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      roff  <= '0;
      rbase <= '0;
    end else if (llr_valid) begin
      if (roff == OW'(WIN - 1)) begin
        roff  <= '0;
        rbase <= (rbase == PW'(DEPTH - WIN)) ? '0 : rbase + PW'(WIN);
      end else begin
        roff <= roff + 1'b1;
      end
    end
  end

  // extrinsic formation
  logic [2*BW-1:0]      rd_word;
  logic signed [BW-1:0] rg3, rg2;
  logic signed [DW-1:0] gsum, diff;

  assign rd_word = mem[raddr];
  assign rg3     = rd_word[2*BW-1:BW];
  assign rg2     = rd_word[BW-1:0];
  assign gsum    = DW'(rg3) + DW'(rg2);
  assign diff    = DW'(llr) - gsum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_valid <= 1'b0;
      ext       <= '0;
    end else begin
      ext_valid <= llr_valid;
      if (llr_valid) ext <= sat_ex(diff);
    end
  end

  a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> gam_valid);
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(gam3) && $stable(gam2) && $stable(gam1) && $stable(gam0)));
  a_r3_neg_no_min: assert property (@(posedge clk) disable iff (!rst_n)
    gam_valid |-> (gam0 != GMIN && gam1 != GMIN));
  a_r3_neg_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (gam_valid && gam3 > 0) |-> (gam0 < 0));
  a_r6_ext_follows: assert property (@(posedge clk) disable iff (!rst_n)
    llr_valid |=> ext_valid);
  a_r7_offset_range: assert property (@(posedge clk) disable iff (!rst_n)
    roff <= OW'(WIN - 1));

endmodule

// File: tb/llr_branch_extrinsic_tb_top.sv
`timescale 1ns/1ps
module llr_branch_extrinsic_tb_top;
  localparam int AW = 9, CW = 10, BW = 10, LW = 12, WIN = 40, NWIN = 4, NW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic                 in_valid, llr_valid;
  logic signed [AW-1:0] apri;
  logic signed [CW-1:0] lc_ys, lc_yp;
  logic signed [LW-1:0] llr;
  logic                 gam_valid, ext_valid;
  logic signed [BW-1:0] gam3, gam2, gam1, gam0;
  logic signed [AW-1:0] ext;

  llr_branch_extrinsic #(.AW(AW), .CW(CW), .BW(BW), .LW(LW), .WIN(WIN), .NWIN(NWIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .apri(apri), .lc_ys(lc_ys), .lc_yp(lc_yp),
    .gam_valid(gam_valid), .gam3(gam3), .gam2(gam2), .gam1(gam1), .gam0(gam0),
    .llr_valid(llr_valid), .llr(llr), .ext_valid(ext_valid), .ext(ext));

  int checks = 0, fails = 0;
  int sum_tab[int];
  int e_g[4];
  bit e_gv, e_ev;
  int e_ext;

  function automatic int sat(int v, int w);
    int hi = (1 << (w - 1)) - 1;
    int lo = -(1 << (w - 1));
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  task automatic chk(string req, int act, int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic compare_all();
    chk("R5 gam_valid", int'(gam_valid), int'(e_gv));
    chk("R1 gam3", int'(gam3), e_g[3]);
    chk("R2 gam2", int'(gam2), e_g[2]);
    chk("R3 gam1", int'(gam1), e_g[1]);
    chk("R3 gam0", int'(gam0), e_g[0]);
    chk("R6 ext_valid", int'(ext_valid), int'(e_ev));
    if (e_ev) chk("R6 R7 ext", int'(ext), e_ext);
  endtask

  initial begin
    int wr_sym = 0, rd_cnt = 0, cyc = 0;
    in_valid = 0; llr_valid = 0; apri = '0; lc_ys = '0; lc_yp = '0; llr = '0;
    e_g = '{0, 0, 0, 0}; e_gv = 0; e_ev = 0; e_ext = 0;
    repeat (3) @(negedge clk);
    // R8: reset state
    compare_all();
    rst_n = 1'b1;
    while (rd_cnt < NW * WIN) begin
      bit do_r, do_w;
      @(negedge clk);
      compare_all();
      cyc++;
      if (cyc > 20000) begin
        fails++;
        $display("FAIL watchdog expired");
        break;
      end
      do_r = (rd_cnt < NW * WIN) && (wr_sym >= (rd_cnt / WIN + 1) * WIN) && ($urandom_range(0, 3) != 0);
      do_w = (wr_sym < NW * WIN) && (wr_sym < (rd_cnt / WIN + NWIN) * WIN) && ($urandom_range(0, 3) != 0);
      e_gv = do_w;
      e_ev = do_r;
      in_valid = do_w;
      llr_valid = do_r;
      if (do_r) begin
        int l, sym, pick;
        pick = int'($urandom_range(0, 3));
        l = (pick == 0) ? 2047 : ((pick == 1) ? -2048 : int'($urandom_range(0, 600)) - 300);
        sym = (rd_cnt / WIN) * WIN + WIN - 1 - (rd_cnt % WIN);
        e_ext = sat(l - sum_tab[sym], AW);   // R6 R7 R4
        llr = LW'(l);
        rd_cnt++;
      end
      if (do_w) begin
        int a, ys, yp, t1, t2;
        if (wr_sym == 0) begin a = 255; ys = 511; yp = 511; end          // R4 positive clamp
        else if (wr_sym == 1) begin a = -256; ys = -512; yp = -512; end  // R4 negative clamp, negation clamp
        else if (wr_sym == 2) begin a = -256; ys = -512; yp = 511; end   // R4 difference clamp
        else begin
          a  = int'($urandom_range(0, 511)) - 256;
          ys = int'($urandom_range(0, 1023)) - 512;
          yp = int'($urandom_range(0, 1023)) - 512;
        end
        t1 = (a + ys) >>> 1;
        t2 = yp >>> 1;
        e_g[3] = sat(t1 + t2, BW);
        e_g[2] = sat(t1 - t2, BW);
        e_g[1] = sat(-e_g[2], BW);
        e_g[0] = sat(-e_g[3], BW);
        sum_tab[wr_sym] = e_g[2] + e_g[3];
        apri = AW'(a); lc_ys = CW'(ys); lc_yp = CW'(yp);
        wr_sym++;
      end
    end
    @(negedge clk);
    compare_all();
    in_valid = 0; llr_valid = 0;
    e_gv = 0; e_ev = 0;
    @(negedge clk);
    compare_all();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule